// File: doc/BRIEF.md
# Processor Power State Controller

This block sequences a processor core through four power states: Working, Halt, Stop Grant and Probe. A stop-clock request is honoured only once the core has no bus cycles outstanding. The block then issues a one-cycle stop-grant special-cycle request. A halt request is honoured under the same idle condition. Once in a sleep state (Halt or Stop Grant), the core reaches low power only after the system controller disconnects the bus. The depth of that low power comes from a clock-control register field.

While the core sleeps, wake events (INIT, INTR, NMI, SMI and local interrupt messages) are latched. Stop Grant is left when stop-clock drops, and Halt is left on any wake event. If the bus is disconnected at that point, the block requests a reconnection and waits for it before it returns to Working. On return it pulses a resume indication, with the latched events presented for service. A bus connect from the system controller while the core is disconnected and asleep opens a Probe detour. When the probe completes, the block returns to whichever sleep state it came from, with the bus still connected. A core reset request overrides every transition.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After the synchronous block reset, `state` is Working (code 0), `bus_conn` is 1, and `sg_cycle`, `recon_req`, `resume`, `reset_start`, `lp_en`, `lp_depth` and `wake_pend` are all 0.
- R2: In Working, `stop_req` is held off while `bus_busy` is 1. In the cycle after `stop_req`=1 and `bus_busy`=0 are sampled together, `state` is Stop Grant (code 2) and `sg_cycle` is 1. `sg_cycle` returns to 0 one cycle later.
- R3: In Working, `halt_req`=1 with `bus_busy`=0 moves the block to Halt (code 1) on the next cycle. When both requests are present, `stop_req` wins.
- R4: A `disc_ind` pulse in Halt or Stop Grant clears `bus_conn`. `lp_en` is 1 exactly while the block is in Halt or Stop Grant with `bus_conn`=0, and `lp_depth` then equals `clk_depth`; otherwise both are 0.
- R5: The bits of `wake_in` (bit0 INIT, bit1 INTR, bit2 NMI, bit3 SMI, bit4 local interrupt message) accumulate into `wake_pend` by OR while the block is in Halt, Stop Grant or Probe. They are ignored in Working.
- R6: In Stop Grant with `stop_req`=0, a connected block returns to Working on the next cycle with `resume`=1. A disconnected block instead raises `recon_req`, holds Stop Grant until `conn_ind` is sampled, and then enters Working with `resume`=1 and `bus_conn`=1.
- R7: Halt is left on any nonzero `wake_in`, by the same connected and reconnecting paths as R6.
- R8: `conn_ind` in Halt or Stop Grant while disconnected, with no exit or reconnection pending, moves the block to Probe (code 3) with `bus_conn`=1 and `lp_en`=0.
- R9: `probe_done` in Probe returns the block to the sleep state held before the probe, still connected. Low power resumes only after a new `disc_ind`.
- R10: `wake_pend` keeps its value during the cycle in which `resume` is 1, and reads 0 on the following cycle.
- R11: `core_rst` takes priority over every transition. On the next cycle the block is in Working with `bus_conn`=1, `reset_start`=1, `recon_req`=0 and `wake_pend`=0.
- R12: `disc_ind` in Working or Probe leaves `bus_conn` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| core_rst | input | 1 | Core reset request, highest priority |
| stop_req | input | 1 | Stop-clock request |
| halt_req | input | 1 | Halt request from the core |
| bus_busy | input | 1 | Bus cycles pending or in progress |
| disc_ind | input | 1 | System controller disconnected the bus |
| conn_ind | input | 1 | System controller connected the bus |
| probe_done | input | 1 | Probe serviced |
| wake_in | input | 5 | Wake events: INIT, INTR, NMI, SMI, local message |
| clk_depth | input | 2 | Low-power depth from the clock-control field |
| state | output | 2 | Power state: 0 Working, 1 Halt, 2 Stop Grant, 3 Probe |
| bus_conn | output | 1 | Bus connected flag |
| sg_cycle | output | 1 | Stop-grant special-cycle request pulse |
| recon_req | output | 1 | Bus reconnection request |
| lp_en | output | 1 | Low-power enable |
| lp_depth | output | 2 | Selected low-power depth |
| wake_pend | output | 5 | Latched wake events |
| resume | output | 1 | Return-to-Working pulse |
| reset_start | output | 1 | Reset sequence start pulse |

## Verification
Every registered result is due one cycle after the inputs that cause it are sampled. This covers `state`, `bus_conn`, `recon_req` and the pulses `sg_cycle`, `resume` and `reset_start`. `lp_en` and `lp_depth` follow the state registers within that same cycle. Clearing `wake_pend` takes one further cycle after `resume`. The bench changes inputs one time unit after a rising edge and checks outputs one time unit after the next edge. Each expected value therefore refers to exactly one sampled edge, including the held-off stop requests over swept busy lengths and every nonzero wake pattern.

// File: rtl/pwr_pkg.sv
// Shared types for the power state controller.
// Assumes the 2-bit state code is visible at the top port as-is.
package pwr_pkg;
    typedef enum logic [1:0] {
        PS_WORK  = 2'd0,
        PS_HALT  = 2'd1,
        PS_STOPG = 2'd2,
        PS_PROBE = 2'd3
    } pstate_t;
endpackage

// File: rtl/pwr_fsm.sv
// Power state sequencer: state, bus-connected flag, probe return slot,
// reconnect request and the one-cycle event pulses.
// Assumes one-cycle pulses on disc_ind/conn_ind/probe_done from the system side.
module pwr_fsm
    import pwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    core_rst,
    input  logic    stop_req,
    input  logic    halt_req,
    input  logic    bus_busy,
    input  logic    disc_ind,
    input  logic    conn_ind,
    input  logic    probe_done,
    input  logic    wake_any,
    output pstate_t state,
    output logic    bus_conn,
    output logic    recon_req,
    output logic    sg_cycle,
    output logic    resume,
    output logic    reset_start
);
    pstate_t nstate;
    logic    nconn, nrecon, nprev, prev_sg;
    logic    n_sg, n_res, n_rs, leave;

    // Next-state selection; core reset overrides everything.
    always_comb begin
        nstate = state;
        nconn  = bus_conn;
        nrecon = recon_req;
        nprev  = prev_sg;
        n_sg   = 1'b0;
        n_res  = 1'b0;
        n_rs   = 1'b0;
        leave  = (state == PS_HALT) ? wake_any : !stop_req;
        if (core_rst) begin
            nstate = PS_WORK;
            nconn  = 1'b1;
            nrecon = 1'b0;
            n_rs   = 1'b1;
        end else begin
            case (state)
                PS_WORK: begin
                    if (stop_req && !bus_busy) begin
                        nstate = PS_STOPG;
                        n_sg   = 1'b1;
                    end else if (halt_req && !bus_busy) begin
                        nstate = PS_HALT;
                    end
                end
                PS_HALT, PS_STOPG: begin
                    if (recon_req) begin
                        if (conn_ind) begin
                            nconn  = 1'b1;
                            nrecon = 1'b0;
                            nstate = PS_WORK;
                            n_res  = 1'b1;
                        end
                    end else if (leave) begin
                        if (bus_conn) begin
                            nstate = PS_WORK;
                            n_res  = 1'b1;
                        end else begin
                            nrecon = 1'b1;
                        end
                    end else if (!bus_conn && conn_ind) begin
                        nstate = PS_PROBE;
                        nconn  = 1'b1;
                        nprev  = (state == PS_STOPG);
                    end else if (bus_conn && disc_ind) begin
                        nconn = 1'b0;
                    end
                end
                default: begin
                    if (probe_done)
                        nstate = prev_sg ? PS_STOPG : PS_HALT;
                end
            endcase
        end
    end

    // State and pulse registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= PS_WORK;
            bus_conn    <= 1'b1;
            recon_req   <= 1'b0;
            prev_sg     <= 1'b0;
            sg_cycle    <= 1'b0;
            resume      <= 1'b0;
            reset_start <= 1'b0;
        end else begin
            state       <= nstate;
            bus_conn    <= nconn;
            recon_req   <= nrecon;
            prev_sg     <= nprev;
            sg_cycle    <= n_sg;
            resume      <= n_res;
            reset_start <= n_rs;
        end
    end

    assert_sg_after_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sg_cycle |-> ($past(state) == PS_WORK && !$past(bus_busy) && state == PS_STOPG));
    assert_core_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> (state == PS_WORK && bus_conn && reset_start && !recon_req));
    assert_resume_connected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (state == PS_WORK && bus_conn));
    assert_recon_disconnected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        recon_req |-> !bus_conn);
    assert_probe_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_PROBE && probe_done && !core_rst) |=>
            ((state == PS_HALT || state == PS_STOPG) && bus_conn));
    assert_probe_connected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_PROBE) |-> bus_conn);
endmodule

// File: rtl/pwr_wake_latch.sv
// Wake event latch: ORs wake inputs in while the core sleeps or is probed,
// clears after the resume pulse or on core reset.
// Assumes resume is a one-cycle pulse in Working.
module pwr_wake_latch
    import pwr_pkg::*;
#(
    parameter int WAKE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_rst,
    input  pstate_t           state,
    input  logic              resume,
    input  logic [WAKE_W-1:0] wake_in,
    output logic [WAKE_W-1:0] wake_pend
);
    logic capture;
    assign capture = (state != PS_WORK);

    // Accumulate pending events; clearing has priority over capture.
    always_ff @(posedge clk) begin
        if (!rst_n || core_rst || resume)
            wake_pend <= '0;
        else if (capture)
            wake_pend <= wake_pend | wake_in;
    end

    assert_work_ignores_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WORK && !resume && !core_rst) |=> $stable(wake_pend));
    assert_cleared_after_resume_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> (wake_pend == '0));
endmodule

// File: rtl/pwr_lp_out.sv
// Low-power output stage: enables low power only while asleep and
// disconnected, and passes the clock-control depth through then.
// Assumes depth field is static while low power is active.
module pwr_lp_out
    import pwr_pkg::*;
#(
    parameter int DEPTH_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pstate_t            state,
    input  logic               bus_conn,
    input  logic [DEPTH_W-1:0] clk_depth,
    output logic               lp_en,
    output logic [DEPTH_W-1:0] lp_depth
);
    // Decode the low-power condition from the sequencer state.
    always_comb begin
        lp_en    = (state == PS_HALT || state == PS_STOPG) && !bus_conn;
        lp_depth = lp_en ? clk_depth : '0;
    end

    assert_lp_needs_disconnect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lp_en |-> !bus_conn);
    assert_no_lp_in_probe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_PROBE || state == PS_WORK) |-> !lp_en);
endmodule

// File: rtl/pwr_state_ctrl.sv
// Top of the processor power state controller: sequencer, wake latch and
// low-power output stage. Assumes all inputs synchronous to clk.
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int WAKE_W  = 5,
    parameter int DEPTH_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_rst,
    input  logic               stop_req,
    input  logic               halt_req,
    input  logic               bus_busy,
    input  logic               disc_ind,
    input  logic               conn_ind,
    input  logic               probe_done,
    input  logic [WAKE_W-1:0]  wake_in,
    input  logic [DEPTH_W-1:0] clk_depth,
    output logic [1:0]         state,
    output logic               bus_conn,
    output logic               sg_cycle,
    output logic               recon_req,
    output logic               lp_en,
    output logic [DEPTH_W-1:0] lp_depth,
    output logic [WAKE_W-1:0]  wake_pend,
    output logic               resume,
    output logic               reset_start
);
    pstate_t st;
    logic    wake_any;

    assign wake_any = |wake_in;
    assign state    = st;

    pwr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .core_rst(core_rst),
        .stop_req(stop_req), .halt_req(halt_req), .bus_busy(bus_busy),
        .disc_ind(disc_ind), .conn_ind(conn_ind), .probe_done(probe_done),
        .wake_any(wake_any), .state(st), .bus_conn(bus_conn),
        .recon_req(recon_req), .sg_cycle(sg_cycle), .resume(resume),
        .reset_start(reset_start)
    );

    pwr_wake_latch #(.WAKE_W(WAKE_W)) u_wake (
        .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .state(st),
        .resume(resume), .wake_in(wake_in), .wake_pend(wake_pend)
    );

    pwr_lp_out #(.DEPTH_W(DEPTH_W)) u_lp (
        .clk(clk), .rst_n(rst_n), .state(st), .bus_conn(bus_conn),
        .clk_depth(clk_depth), .lp_en(lp_en), .lp_depth(lp_depth)
    );
endmodule

// File: tb/test_pwr_state_ctrl.sv
module test_pwr_state_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_rst = 1'b0, stop_req = 1'b0, halt_req = 1'b0, bus_busy = 1'b0;
    logic       disc_ind = 1'b0, conn_ind = 1'b0, probe_done = 1'b0;
    logic [4:0] wake_in = '0;
    logic [1:0] clk_depth = '0;
    logic [1:0] state;
    logic       bus_conn, sg_cycle, recon_req, lp_en, resume, reset_start;
    logic [1:0] lp_depth;
    logic [4:0] wake_pend;
    int         n_vec = 0, n_bad = 0;

    always #4 clk = ~clk;

    pwr_state_ctrl i_pwr_state_ctrl (
        .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .stop_req(stop_req),
        .halt_req(halt_req), .bus_busy(bus_busy), .disc_ind(disc_ind),
        .conn_ind(conn_ind), .probe_done(probe_done), .wake_in(wake_in),
        .clk_depth(clk_depth), .state(state), .bus_conn(bus_conn),
        .sg_cycle(sg_cycle), .recon_req(recon_req), .lp_en(lp_en),
        .lp_depth(lp_depth), .wake_pend(wake_pend), .resume(resume),
        .reset_start(reset_start)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_disc();
        disc_ind = 1'b1; tick(); disc_ind = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset values
        chk("R1 state", state, 0);
        chk("R1 conn", bus_conn, 1);
        chk("R1 outs", {sg_cycle, recon_req, resume, reset_start, lp_en}, 0);
        chk("R1 pend", wake_pend, 0);

        // R2 hold-off sweep over busy lengths, then connected exit R6
        for (int w = 0; w < 4; w++) begin
            stop_req = 1'b1; bus_busy = 1'b1;
            for (int k = 0; k < w; k++) begin
                tick();
                chk("R2 held", state, 0);
                chk("R2 no sg", sg_cycle, 0);
            end
            bus_busy = 1'b0;
            tick();
            chk("R2 stopg", state, 2);
            chk("R2 sg", sg_cycle, 1);
            tick();
            chk("R2 sg pulse", sg_cycle, 0);
            chk("R4 no lp connected", lp_en, 0);
            stop_req = 1'b0;
            tick();
            chk("R6 work", state, 0);
            chk("R6 resume", resume, 1);
            tick();
            chk("R6 resume pulse", resume, 0);
        end

        // R3 stop priority over halt
        stop_req = 1'b1; halt_req = 1'b1;
        tick();
        chk("R3 stop wins", state, 2);
        stop_req = 1'b0; halt_req = 1'b0;
        tick(); tick();

        // R4/R7 halt depth sweep with disconnected wake exit
        for (int d = 0; d < 4; d++) begin
            clk_depth = 2'(d);
            halt_req = 1'b1;
            tick();
            halt_req = 1'b0;
            chk("R3 halt", state, 1);
            pulse_disc();
            chk("R4 conn", bus_conn, 0);
            chk("R4 lp", lp_en, 1);
            chk("R4 depth", lp_depth, d);
            wake_in = 5'(1 << d);
            tick();
            wake_in = '0;
            chk("R7 recon", recon_req, 1);
            chk("R7 still halt", state, 1);
            conn_ind = 1'b1; tick(); conn_ind = 1'b0;
            chk("R7 work", state, 0);
            chk("R7 resume", resume, 1);
            chk("R10 pend held", wake_pend, 1 << d);
            chk("R4 lp off", lp_en, 0);
            tick();
            chk("R10 pend clear", wake_pend, 0);
        end

        // R5/R6/R10 wake pattern sweep in Stop Grant
        for (int p = 1; p < 32; p++) begin
            stop_req = 1'b1;
            tick();
            pulse_disc();
            wake_in = 5'(p);
            tick();
            wake_in = 5'(p & 1);
            tick();
            wake_in = '0;
            chk("R5 latch", wake_pend, p);
            stop_req = 1'b0;
            tick();
            chk("R6 recon", recon_req, 1);
            chk("R6 wait", state, 2);
            conn_ind = 1'b1; tick(); conn_ind = 1'b0;
            chk("R6 work", state, 0);
            chk("R6 resume", {resume, bus_conn}, 3);
            chk("R10 held", wake_pend, p);
            tick();
            chk("R10 cleared", wake_pend, 0);
        end

        // R5/R12 ignored in Working
        wake_in = 5'd5; disc_ind = 1'b1;
        tick();
        wake_in = '0; disc_ind = 1'b0;
        chk("R5 ignored", wake_pend, 0);
        chk("R12 work disc", bus_conn, 1);

        // R8/R9 probe detours from both sleep states
        for (int s = 0; s < 2; s++) begin
            if (s == 0) halt_req = 1'b1; else stop_req = 1'b1;
            tick();
            halt_req = 1'b0;
            pulse_disc();
            conn_ind = 1'b1; tick(); conn_ind = 1'b0;
            chk("R8 probe", state, 3);
            chk("R8 conn", {bus_conn, lp_en}, 2);
            pulse_disc();
            chk("R12 probe disc", bus_conn, 1);
            probe_done = 1'b1; tick(); probe_done = 1'b0;
            chk("R9 return", state, s == 0 ? 1 : 2);
            chk("R9 no lp", {bus_conn, lp_en}, 2);
            pulse_disc();
            chk("R9 lp again", lp_en, 1);
            if (s == 0) wake_in = 5'd1; else stop_req = 1'b0;
            tick();
            wake_in = '0;
            conn_ind = 1'b1; tick(); conn_ind = 1'b0;
            chk("R9 back work", state, 0);
            tick();
        end

        // R11 core reset from a disconnected Stop Grant with pending wakes
        stop_req = 1'b1;
        tick();
        pulse_disc();
        wake_in = 5'd3;
        tick();
        wake_in = '0;
        core_rst = 1'b1; stop_req = 1'b0;
        tick();
        core_rst = 1'b0;
        chk("R11 work", state, 0);
        chk("R11 conn", bus_conn, 1);
        chk("R11 start", reset_start, 1);
        chk("R11 pend", wake_pend, 0);
        chk("R11 recon", recon_req, 0);
        tick();
        chk("R11 pulse", reset_start, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule